// File: doc/BRIEF.md
# Timer Count-Enable Prescaler

This block sits in front of a 16-bit timer and decides, every system clock cycle, whether the timer may advance. It produces a single-cycle count-enable pulse `cnt_tick`. A 3-bit select input picks the pulse source. The source can be nothing (the timer is stopped), one of five fixed fractions of the system clock, or the rising or falling edges of an external clock pin. The external pin is asynchronous and is synchronized inside the block.

All five ratios share one 10-bit free-running divider. The pulse for ratio N fires in each cycle where the low log2(N) bits of the divider are all ones. The divider is held at zero whenever no internal ratio is selected. A new internal period therefore always starts at full length, both after a stop and after switching over from the external pin. A prescaler-clear strobe restarts the divider from zero while a ratio is running.

Top module: `tmr_clk_prescaler`

## Requirements
- R1: With select code 0 the block is stopped. `cnt_tick` stays low whatever the external pin and the clear strobe do.
- R2: Select code 1 divides by 1. `cnt_tick` is high in every cycle where `psc_clear` is low.
- R3: Select codes 2, 3, 4 and 5 divide by 8, 64, 256 and 1024. Starting from a held divider, the first pulse comes N-1 cycles after the cycle in which the code is first applied, and each later pulse follows N cycles after the one before.
- R4: Select code 7 gives one pulse per rising edge of `ext_clk_in`. A level change that is first captured at clock edge k produces the pulse in the cycle that follows edge k+1, two cycles after the pin moved.
- R5: Select code 6 gives one pulse per falling edge of `ext_clk_in`, with the same latency as R4. Rising edges produce no pulse.
- R6: A change from code 0 to any internal ratio code starts a fresh time base. A divider that was stopped part-way through a period does not resume from its old count.
- R7: While an internal ratio is running, a high `psc_clear` suppresses any pulse in that same cycle and returns the divider to zero at the next edge. The next pulse then comes a full N cycles after the strobe cycle. The strobe has no effect on the external-edge codes.
- R8: In codes 0, 6 and 7 the divider is held at zero. Switching directly from an external-edge code to an internal ratio gives a full first period.
- R9: While `rst_n` is low, `cnt_tick` is low, and the divider and synchronizer are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| clk_sel | input | 3 | Pulse source: 0 stop, 1..5 divide by 1/8/64/256/1024, 6 falling pin edge, 7 rising pin edge |
| psc_clear | input | 1 | Restarts the shared divider from zero |
| ext_clk_in | input | 1 | Asynchronous external clock pin |
| cnt_tick | output | 1 | Single-cycle count-enable pulse |

## Verification
Two functions can land in the same cycle. The first case is a clear strobe falling exactly in the cycle where a ratio's tap reaches all ones. The bench places the strobe on that cycle for divide-by-8 and divide-by-1, and also part-way through a period. It expects the due pulse to vanish and the next one to come a full period after the strobe. The second case is a change of select code that arrives together with a pending divider state, either a restart out of stop after a partial period or a direct switch from an edge code to a ratio. There the scoreboard expects the first pulse at exactly N-1 cycles.

// File: rtl/tmr_psc_pkg.sv
package tmr_psc_pkg;

  parameter int PSC_DIV_W = 10;

  typedef enum logic [2:0] {
    SEL_STOP     = 3'd0,
    SEL_DIV1     = 3'd1,
    SEL_DIV8     = 3'd2,
    SEL_DIV64    = 3'd3,
    SEL_DIV256   = 3'd4,
    SEL_DIV1024  = 3'd5,
    SEL_EXT_FALL = 3'd6,
    SEL_EXT_RISE = 3'd7
  } tick_src_e;

  // number of low divider bits that must be all ones for a ratio
  function automatic int unsigned tap_width(input tick_src_e s);
    case (s)
      SEL_DIV8:    return 3;
      SEL_DIV64:   return 6;
      SEL_DIV256:  return 8;
      SEL_DIV1024: return 10;
      default:     return 0;
    endcase
  endfunction

  function automatic logic tap_all_ones(input logic [PSC_DIV_W-1:0] cnt,
                                        input int unsigned w);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < PSC_DIV_W; i++) begin
      if (i < w && !cnt[i]) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic is_ratio(input tick_src_e s);
    return (s != SEL_STOP) && (s != SEL_EXT_FALL) && (s != SEL_EXT_RISE);
  endfunction

endpackage

// File: rtl/psc_divider.sv
module psc_divider #(
  parameter int W = tmr_psc_pkg::PSC_DIV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clear,
  output logic [W-1:0] cnt_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear || !run) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/psc_ext_edge.sv
module psc_ext_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  localparam int CHAIN_W = SYNC_STAGES + 1;

  // stages 0..SYNC_STAGES-1 synchronize, the last one holds the prior level
  logic [CHAIN_W-1:0] chain_q;

  generate
    for (genvar g = 0; g < CHAIN_W; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rise =  chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  assign fall = ~chain_q[SYNC_STAGES-1] &  chain_q[SYNC_STAGES];

endmodule

// File: rtl/psc_tick_mux.sv
module psc_tick_mux
  import tmr_psc_pkg::*;
(
  input  logic                 enable,
  input  tick_src_e            sel,
  input  logic [PSC_DIV_W-1:0] div_cnt,
  input  logic                 clear,
  input  logic                 ext_rise,
  input  logic                 ext_fall,
  output logic                 tick
);

  logic tap_hit;

  always_comb begin
    tap_hit = tap_all_ones(div_cnt, tap_width(sel));
    case (sel)
      SEL_STOP:     tick = 1'b0;
      SEL_EXT_FALL: tick = ext_fall;
      SEL_EXT_RISE: tick = ext_rise;
      default:      tick = tap_hit && !clear;
    endcase
    tick = tick && enable;
  end

endmodule

// File: rtl/tmr_clk_prescaler.sv
module tmr_clk_prescaler
  import tmr_psc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clk_sel,
  input  logic       psc_clear,
  input  logic       ext_clk_in,
  output logic       cnt_tick
);

  localparam int MAX_RATIO = 1 << PSC_DIV_W;

  tick_src_e            sel_e;
  logic                 div_run;
  logic [PSC_DIV_W-1:0] div_cnt;
  logic                 ext_rise;
  logic                 ext_fall;

  assign sel_e   = tick_src_e'(clk_sel);
  assign div_run = is_ratio(sel_e);

  psc_divider #(.W(PSC_DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (div_run),
    .clear (psc_clear),
    .cnt_q (div_cnt)
  );

  psc_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (ext_clk_in),
    .rise  (ext_rise),
    .fall  (ext_fall)
  );

  psc_tick_mux u_mux (
    .enable   (rst_n),
    .sel      (sel_e),
    .div_cnt  (div_cnt),
    .clear    (psc_clear),
    .ext_rise (ext_rise),
    .ext_fall (ext_fall),
    .tick     (cnt_tick)
  );

endmodule

// File: rtl/tmr_clk_prescaler_chk.sv
module tmr_clk_prescaler_chk #(
  parameter int DIV_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       clk_sel,
  input logic             psc_clear,
  input logic             ext_clk_in,
  input logic             cnt_tick,
  input logic [DIV_W-1:0] div_cnt,
  input logic             ext_rise,
  input logic             ext_fall
);

  // cycles since reset, saturating, so that deep $past is only used when valid
  logic [1:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  p_stop_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0) |-> !cnt_tick);

  p_div1_every_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd1 && !psc_clear) |-> cnt_tick);

  p_div8_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd2 && cnt_tick) |=> (clk_sel != 3'd2 || !cnt_tick));

  p_rise_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == 2'd3 && clk_sel == 3'd7 && cnt_tick)
      |-> ($past(ext_clk_in, 2) && !$past(ext_clk_in, 3) && ext_rise));

  p_fall_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == 2'd3 && clk_sel == 3'd6 && cnt_tick)
      |-> (!$past(ext_clk_in, 2) && $past(ext_clk_in, 3) && ext_fall));

  p_restart_fresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clk_sel) == 3'd0 && clk_sel inside {[3'd1:3'd5]}) |-> (div_cnt == '0));

  p_clear_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (psc_clear && clk_sel inside {[3'd1:3'd5]}) |-> !cnt_tick);

  p_clear_zeroes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    psc_clear |=> (div_cnt == '0));

  p_held_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clk_sel) inside {3'd0, 3'd6, 3'd7}) |-> (div_cnt == '0));

  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r9: assert (!cnt_tick);
    end
  end

endmodule

bind tmr_clk_prescaler tmr_clk_prescaler_chk #(.DIV_W(tmr_psc_pkg::PSC_DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_sel    (clk_sel),
  .psc_clear  (psc_clear),
  .ext_clk_in (ext_clk_in),
  .cnt_tick   (cnt_tick),
  .div_cnt    (div_cnt),
  .ext_rise   (ext_rise),
  .ext_fall   (ext_fall)
);

// File: tb/test_tmr_clk_prescaler.sv
`timescale 1ns/1ps
module test_tmr_clk_prescaler;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic       psc_clear = 1'b0;
  logic       ext_clk_in = 1'b0;
  logic       cnt_tick;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  string cur_req = "R9";
  bit done = 1'b0;

  typedef struct {
    int    at;
    string req;
  } exp_t;
  exp_t exp_q[$];
  exp_t item;

  tmr_clk_prescaler i_tmr_clk_prescaler (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_sel    (clk_sel),
    .psc_clear  (psc_clear),
    .ext_clk_in (ext_clk_in),
    .cnt_tick   (cnt_tick)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: every sampled pulse must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && cnt_tick === 1'b1) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL %s: pulse at cycle %0d, expected none", cur_req, cyc);
      end else begin
        item = exp_q.pop_front();
        if (item.at != cyc) begin
          n_fail++;
          $display("FAIL %s: pulse at cycle %0d, expected cycle %0d", item.req, cyc, item.at);
        end
      end
    end
  end

  task automatic push(input int at, input string req);
    exp_t e;
    e.at  = at;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drain(input string req);
    repeat (3) step();
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s: %0d pulses missing, expected 0 outstanding", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  // internal ratio run starting from a held divider
  task automatic run_div(input logic [2:0] code, input int n, input int len, input string req);
    int k0;
    step();
    clk_sel = code;
    cur_req = req;
    k0 = cyc;
    for (int m = k0 + n - 1; m < k0 + len; m += n) push(m, req);
    repeat (len) step();
    clk_sel = 3'd0;
    drain(req);
  endtask

  // ratio run with a clear strobe d cycles after start
  task automatic run_clear(input logic [2:0] code, input int n, input int d,
                           input int len, input string req);
    int k0;
    int k1;
    step();
    clk_sel = code;
    cur_req = req;
    k0 = cyc;
    k1 = k0 + d;
    for (int m = k0 + n - 1; m < k1; m += n) push(m, req);
    for (int m = k1 + n; m < k0 + len; m += n) push(m, req);
    while (cyc < k1) step();
    psc_clear = 1'b1;
    step();
    psc_clear = 1'b0;
    while (cyc < k0 + len) step();
    clk_sel = 3'd0;
    drain(req);
  endtask

  // edge-driven run; leaves the code applied
  task automatic run_ext(input logic [2:0] code, input int toggles, input string req);
    int p;
    step();
    clk_sel = code;
    cur_req = req;
    repeat (4) step();
    for (int i = 0; i < toggles; i++) begin
      ext_clk_in = ~ext_clk_in;
      p = cyc;
      if ((code == 3'd7 && ext_clk_in) || (code == 3'd6 && !ext_clk_in)) push(p + 2, req);
      if (i == 1) psc_clear = 1'b1;
      step();
      psc_clear = 1'b0;
      repeat (4) step();
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_up();
  end

  initial begin
    // R9: reset holds the pulse low even with divide-by-1 selected
    clk_sel = 3'd1;
    repeat (3) @(negedge clk);
    n_chk++;
    if (cnt_tick !== 1'b0) begin
      n_fail++;
      $display("FAIL R9: cnt_tick=%b during reset, expected 0", cnt_tick);
    end
    step();
    clk_sel = 3'd0;
    rst_n = 1'b1;
    repeat (2) step();

    // R1: stopped, pin toggling and strobes change nothing
    cur_req = "R1";
    for (int i = 0; i < 6; i++) begin
      ext_clk_in = ~ext_clk_in;
      psc_clear = (i == 2);
      repeat (3) step();
    end
    psc_clear = 1'b0;
    ext_clk_in = 1'b0;
    drain("R1");

    // R2: divide by 1
    run_div(3'd1, 1, 12, "R2");

    // R3: the four coarse ratios
    run_div(3'd2, 8, 40, "R3");
    run_div(3'd3, 64, 200, "R3");
    run_div(3'd4, 256, 600, "R3");
    run_div(3'd5, 1024, 2100, "R3");

    // R6: stop part-way through a period, then restart
    run_div(3'd2, 8, 13, "R6");
    run_div(3'd2, 8, 20, "R6");

    // R7: strobe on the due cycle, mid-period, and with divide-by-1
    run_clear(3'd2, 8, 7, 40, "R7");
    run_clear(3'd2, 8, 3, 30, "R7");
    run_clear(3'd1, 1, 4, 10, "R7");

    // R4 / R5: external edges
    run_ext(3'd7, 6, "R4");
    clk_sel = 3'd0;
    drain("R4");
    ext_clk_in = 1'b0;
    repeat (4) step();
    run_ext(3'd6, 6, "R5");
    clk_sel = 3'd0;
    drain("R5");
    ext_clk_in = 1'b0;
    repeat (4) step();

    // R8: direct switch from edge code to a ratio
    run_ext(3'd7, 2, "R8");
    repeat (3) step();
    run_div(3'd2, 8, 25, "R8");

    finish_up();
  end

endmodule